// File: doc/BRIEF.md
# Sample Buffer Writer with Half and Full Events

This block sits between a scan sequencer, which delivers one converted 16-bit result at a time, and a sample memory. It stores the results group by group. A group holds M channel results, and the buffer holds N groups. The block drives the memory write strobe, the address and the data. It holds each write until the memory grants it.

Software or a controller sets the channel count, the group depth and the mode, then pulses `start`.

- In linear mode the block fills the buffer once. It reports one event that covers the whole buffer and then goes idle.
- In circular mode it reports an event when the lower half of the buffer is filled and another when the upper half is filled. It then wraps to the base and carries on until `stop`. A consumer can therefore work on one half while the other half is being refilled.

A configuration that is not allowed is refused. A result that arrives while the previous write is still waiting for the memory is dropped and flagged.

Top module: `sbuf_writer`

## Requirements
- R1: A `start` while idle is refused when the group depth is zero, odd or above DEPTH_MAX, or the channel count is zero or above CH_MAX. When refused, `busy` stays 0 and `cfg_err` reads 1 on the next cycle. `cfg_err` returns to 0 on the next accepted start.
- R2: The k-th result accepted since a start is written at address k modulo N×M. So channel c of group g lands at g×M+c, and the data is written unchanged.
- R3: A result that is accepted on a clock edge raises `mem_we` from the next cycle. `mem_we`, `mem_addr` and `mem_wdata` stay fixed until the cycle in which `mem_ready` is 1; that cycle completes the write.
- R4: In circular mode, when the write to address N×M/2−1 completes, `evt_valid` pulses for one cycle on the following cycle, with `evt_base` = 0 and `evt_size` = N×M/2.
- R5: In circular mode, when the write to address N×M−1 completes, the event that follows carries `evt_base` = N×M/2 and `evt_size` = N×M/2. The next result goes to address 0 and `busy` stays 1.
- R6: In linear mode, when the write to address N×M−1 completes, exactly one event follows, with `evt_base` = 0 and `evt_size` = N×M. `busy` falls in that same cycle, and later results cause no write.
- R7: A `stop` while busy clears `busy` and `mem_we` on the next cycle. It drops any write not yet granted and suppresses any event. The next start writes from address 0.
- R8: A result offered while a write is pending and `mem_ready` is 0 is discarded, and `ovf_err` reads 1 on the next cycle. The next accepted result takes the following address. `ovf_err` holds until the next accepted start.
- R9: Results offered while idle cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_circular | input | 1 | 1 selects circular mode, 0 selects linear mode; sampled on start |
| cfg_chans | input | CW (5) | Results per group, M; sampled on start |
| cfg_depth | input | NW (7) | Groups in the buffer, N; sampled on start |
| start | input | 1 | Begin acquisition (used only while idle) |
| stop | input | 1 | End acquisition |
| smp_valid | input | 1 | A result is offered this cycle |
| smp_data | input | DW (16) | Result value, unsigned |
| mem_ready | input | 1 | Memory grants the pending write this cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | AW (10) | Word address of the write |
| mem_wdata | output | DW (16) | Word to write |
| evt_valid | output | 1 | One-cycle buffer event |
| evt_base | output | AW (10) | First address of the region just filled |
| evt_size | output | SW (11) | Words in the region just filled |
| busy | output | 1 | Acquisition active |
| cfg_err | output | 1 | Last start was refused |
| ovf_err | output | 1 | A result was lost since the last start |

## Verification
Every result passes through one register before it appears as a write request. The request then completes on the first clock edge with `mem_ready` high. An event is registered from that completion, so it shows one cycle after the grant, and refusals, overflow flags and stops all show on the cycle after their cause.

The bench samples outputs a quarter period after the falling edge. It logs the cycle index of each grant and each event, and checks that every event index equals the index of its closing grant plus one. Directed steps compare the outputs exactly one cycle after each stimulus.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } sbw_state_e;

endpackage

// File: rtl/sbw_cfg_check.sv
module sbw_cfg_check #(
  parameter int CH_MAX    = 16,
  parameter int DEPTH_MAX = 64,
  parameter int CW        = 5,
  parameter int NW        = 7,
  parameter int SW        = 11
) (
  input  logic [CW-1:0] cfg_chans,
  input  logic [NW-1:0] cfg_depth,
  output logic          cfg_ok,
  output logic [SW-1:0] total_cnt,
  output logic [SW-1:0] half_cnt
);

  localparam int PW = CW + NW;

  logic          chans_ok;
  logic          depth_ok;
  logic [PW-1:0] prod;

  // channel count within 1..CH_MAX
  assign chans_ok = (cfg_chans != '0) && (cfg_chans <= CW'(CH_MAX));

  // depth nonzero, even, within DEPTH_MAX
  assign depth_ok = (cfg_depth != '0) && !cfg_depth[0] &&
                    (cfg_depth <= NW'(DEPTH_MAX));

  assign cfg_ok = chans_ok && depth_ok;

  always_comb begin
    prod      = PW'(cfg_chans) * PW'(cfg_depth);
    total_cnt = SW'(prod);
    half_cnt  = total_cnt >> 1;
  end

endmodule

// File: rtl/sbw_ptr.sv
module sbw_ptr #(
  parameter int AW = 10,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [SW-1:0] total_cnt,
  input  logic [SW-1:0] half_cnt,
  output logic [AW-1:0] addr,
  output logic          at_half_last,
  output logic          at_last
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign at_last      = (SW'(addr_q) == (total_cnt - SW'(1)));
  assign at_half_last = (SW'(addr_q) == (half_cnt - SW'(1)));

  always_comb begin
    addr_en = clr || adv;
    addr_d  = addr_q;
    if (clr) begin
      addr_d = '0;
    end else if (adv) begin
      addr_d = at_last ? '0 : addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R2: an advancing pointer never points past the configured buffer
  assert_addr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (SW'(addr_q) < total_cnt));

endmodule

// File: rtl/sbw_wr_stage.sv
module sbw_wr_stage #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_tag_half,
  input  logic          ld_tag_full,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pending,
  output logic          done,
  output logic          done_half,
  output logic          done_full
);

  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          tag_half_q, tag_full_q;

  always_comb begin
    pend_d = pend_q;
    if (flush) begin
      pend_d = 1'b0;
    end else if (load) begin
      pend_d = 1'b1;
    end else if (pend_q && mem_ready) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      data_q     <= '0;
      tag_half_q <= 1'b0;
      tag_full_q <= 1'b0;
    end else if (load) begin
      addr_q     <= ld_addr;
      data_q     <= ld_data;
      tag_half_q <= ld_tag_half;
      tag_full_q <= ld_tag_full;
    end
  end

  assign mem_we    = pend_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign pending   = pend_q;
  assign done      = pend_q && mem_ready;
  assign done_half = done && tag_half_q;
  assign done_full = done && tag_full_q;

  // R3: an ungranted write keeps its address and data
  assert_hold_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !mem_ready && !flush) |=>
      (pend_q && $stable(addr_q) && $stable(data_q)));

  // R8: the controller never loads over an ungranted write
  assert_no_load_over_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !mem_ready) |-> !load);

endmodule

// File: rtl/sbuf_writer.sv
module sbuf_writer #(
  parameter int CH_MAX    = 16,
  parameter int DEPTH_MAX = 64,
  parameter int DW        = 16,
  localparam int CW = $clog2(CH_MAX + 1),
  localparam int NW = $clog2(DEPTH_MAX + 1),
  localparam int AW = $clog2(CH_MAX * DEPTH_MAX),
  localparam int SW = $clog2(CH_MAX * DEPTH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_circular,
  input  logic [CW-1:0] cfg_chans,
  input  logic [NW-1:0] cfg_depth,
  input  logic          start,
  input  logic          stop,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          evt_valid,
  output logic [AW-1:0] evt_base,
  output logic [SW-1:0] evt_size,
  output logic          busy,
  output logic          cfg_err,
  output logic          ovf_err
);

  import sbw_pkg::*;

  sbw_state_e    state_q, state_d;

  logic          cfg_ok;
  logic [SW-1:0] total_in, half_in;
  logic          circ_q;
  logic [SW-1:0] total_q, half_q;

  logic          idle, running;
  logic          start_ok, start_bad;
  logic          flush, accept, overflow;

  logic [AW-1:0] ptr_addr;
  logic          ptr_half_last, ptr_last;

  logic          pending, done, done_half, done_full;

  logic          evt_fire;
  logic          evt_valid_q;
  logic [AW-1:0] evt_base_q, evt_base_d;
  logic [SW-1:0] evt_size_q, evt_size_d;
  logic          cfg_err_q, cfg_err_d;
  logic          ovf_err_q, ovf_err_d;

  // configuration check on the live inputs
  sbw_cfg_check #(
    .CH_MAX   (CH_MAX),
    .DEPTH_MAX(DEPTH_MAX),
    .CW       (CW),
    .NW       (NW),
    .SW       (SW)
  ) u_cfg (
    .cfg_chans(cfg_chans),
    .cfg_depth(cfg_depth),
    .cfg_ok   (cfg_ok),
    .total_cnt(total_in),
    .half_cnt (half_in)
  );

  // control decode
  assign idle      = (state_q == ST_IDLE);
  assign running   = (state_q == ST_RUN);
  assign start_ok  = start && idle && cfg_ok;
  assign start_bad = start && idle && !cfg_ok;
  assign flush     = stop && !idle;
  assign accept    = running && !stop && smp_valid && (!pending || mem_ready);
  assign overflow  = running && !stop && smp_valid && pending && !mem_ready;

  // latched configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      circ_q  <= 1'b0;
      total_q <= '0;
      half_q  <= '0;
    end else if (start_ok) begin
      circ_q  <= cfg_circular;
      total_q <= total_in;
      half_q  <= half_in;
    end
  end

  // write pointer
  sbw_ptr #(
    .AW(AW),
    .SW(SW)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (flush),
    .adv         (accept),
    .total_cnt   (total_q),
    .half_cnt    (half_q),
    .addr        (ptr_addr),
    .at_half_last(ptr_half_last),
    .at_last     (ptr_last)
  );

  // write request stage
  sbw_wr_stage #(
    .AW(AW),
    .DW(DW)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .load       (accept),
    .ld_addr    (ptr_addr),
    .ld_data    (smp_data),
    .ld_tag_half(circ_q && ptr_half_last),
    .ld_tag_full(ptr_last),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pending    (pending),
    .done       (done),
    .done_half  (done_half),
    .done_full  (done_full)
  );

  // state machine
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (stop) begin
          state_d = ST_IDLE;
        end else if (accept && ptr_last && !circ_q) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (stop || done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // events
  always_comb begin
    evt_fire   = (done_half || done_full) && !flush;
    evt_base_d = (done_full && circ_q) ? AW'(half_q) : '0;
    evt_size_d = circ_q ? half_q : total_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid_q <= 1'b0;
    end else begin
      evt_valid_q <= evt_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_base_q <= '0;
      evt_size_q <= '0;
    end else if (evt_fire) begin
      evt_base_q <= evt_base_d;
      evt_size_q <= evt_size_d;
    end
  end

  // sticky error flags
  always_comb begin
    cfg_err_d = cfg_err_q;
    if (start_bad)     cfg_err_d = 1'b1;
    else if (start_ok) cfg_err_d = 1'b0;
    ovf_err_d = ovf_err_q;
    if (start_ok)      ovf_err_d = 1'b0;
    else if (overflow) ovf_err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err_q <= 1'b0;
      ovf_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_err_d;
      ovf_err_q <= ovf_err_d;
    end
  end

  assign evt_valid = evt_valid_q;
  assign evt_base  = evt_base_q;
  assign evt_size  = evt_size_q;
  assign busy      = !idle;
  assign cfg_err   = cfg_err_q;
  assign ovf_err   = ovf_err_q;

  // R1: a refused start leaves the block idle with the error raised
  assert_cfg_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cfg_ok) |=> (!busy && cfg_err));

  // R4: every event follows a granted write
  assert_evt_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(mem_we && mem_ready));

  // R6: leaving the busy state without a stop comes with the final event
  assert_linear_end_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(stop)) |-> evt_valid);

  // R7: stop ends acquisition with no write and no event
  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && busy) |=> (!busy && !mem_we && !evt_valid));

  // R8: the lost-result flag only clears on a start
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !start) |=> ovf_err);

endmodule

// File: tb/tb_sbuf_writer.sv
module tb_sbuf_writer;

  localparam int PER = 10;
  localparam int CW  = 5;
  localparam int NW  = 7;
  localparam int AW  = 10;
  localparam int SW  = 11;
  localparam int LOGN = 128;

  // vector: {circular, chans[4:0], depth[6:0], gap[1:0]}
  localparam int NVEC = 6;
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {1'b1, 5'd3,  7'd10, 2'd0},
    {1'b0, 5'd3,  7'd10, 2'd1},
    {1'b1, 5'd1,  7'd2,  2'd0},
    {1'b0, 5'd16, 7'd2,  2'd2},
    {1'b1, 5'd4,  7'd6,  2'd1},
    {1'b0, 5'd1,  7'd64, 2'd0}
  };

  logic          clk, rst_n;
  logic          cfg_circular;
  logic [CW-1:0] cfg_chans;
  logic [NW-1:0] cfg_depth;
  logic          start, stop, smp_valid, mem_ready;
  logic [15:0]   smp_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          evt_valid;
  logic [AW-1:0] evt_base;
  logic [SW-1:0] evt_size;
  logic          busy, cfg_err, ovf_err;

  int n_chk, n_fail, cyc;
  int n_wr, n_ev;
  int wr_addr [0:LOGN-1];
  int wr_data [0:LOGN-1];
  int wr_cyc  [0:LOGN-1];
  int ev_base [0:15];
  int ev_size [0:15];
  int ev_cyc  [0:15];
  logic [15:0] ram [0:1023];

  sbuf_writer dut (
    .clk(clk), .rst_n(rst_n), .cfg_circular(cfg_circular),
    .cfg_chans(cfg_chans), .cfg_depth(cfg_depth), .start(start), .stop(stop),
    .smp_valid(smp_valid), .smp_data(smp_data), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .evt_valid(evt_valid), .evt_base(evt_base), .evt_size(evt_size),
    .busy(busy), .cfg_err(cfg_err), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  // sample memory
  always @(posedge clk) if (mem_we && mem_ready) ram[mem_addr] <= mem_wdata;

  // monitor: a quarter period after the falling edge
  initial begin
    cyc = 0; n_wr = 0; n_ev = 0;
    forever begin
      @(negedge clk);
      #(PER/4);
      cyc++;
      if (rst_n) begin
        if (mem_we && mem_ready && n_wr < LOGN) begin
          wr_addr[n_wr] = int'(mem_addr);
          wr_data[n_wr] = int'(mem_wdata);
          wr_cyc[n_wr]  = cyc;
          n_wr++;
        end
        if (evt_valid && n_ev < 16) begin
          ev_base[n_ev] = int'(evt_base);
          ev_size[n_ev] = int'(evt_size);
          ev_cyc[n_ev]  = cyc;
          n_ev++;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit c, input int m, input int n);
    cfg_circular = c;
    cfg_chans    = CW'(m);
    cfg_depth    = NW'(n);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  task automatic send(input int d);
    smp_valid = 1'b1; smp_data = 16'(d); tick(); smp_valid = 1'b0;
  endtask

  task automatic clear_log();
    n_wr = 0; n_ev = 0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; smp_valid = 1'b0;
    smp_data = '0; mem_ready = 1'b1;
    set_cfg(1'b0, 1, 2);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    chk(!busy && !mem_we && !evt_valid, "reset", int'(busy), 0);
    chk(!cfg_err && !ovf_err, "reset", int'(cfg_err | ovf_err), 0);

    // table of configurations
    for (int vi = 0; vi < NVEC; vi++) begin
      automatic bit c   = VEC[vi][14];
      automatic int m   = int'(VEC[vi][13:9]);
      automatic int n   = int'(VEC[vi][8:2]);
      automatic int gap = int'(VEC[vi][1:0]);
      automatic int tot = m * n;
      automatic int hlf = tot / 2;
      automatic int ns  = c ? tot + hlf : tot + 3;
      automatic int bad;
      set_cfg(c, m, n);
      pulse_start();
      chk(busy, "R2 start", int'(busy), 1);
      clear_log();
      for (int k = 0; k < ns; k++) begin
        send(vi * 4096 + k);
        repeat (gap) tick();
      end
      repeat (4) tick();
      bad = 0;
      if (c) begin
        chk(n_wr == tot + hlf, "R2 write count", n_wr, tot + hlf);
        for (int k = 0; k < n_wr; k++)
          if (wr_addr[k] != k % tot || wr_data[k] != vi * 4096 + k) bad++;
        chk(bad == 0, "R2 address order", bad, 0);
        chk(n_ev == 3, "R4 event count", n_ev, 3);
        chk(ev_base[0] == 0 && ev_size[0] == hlf, "R4 half event", ev_size[0], hlf);
        chk(ev_cyc[0] == wr_cyc[hlf-1] + 1, "R4 half timing", ev_cyc[0], wr_cyc[hlf-1] + 1);
        chk(ev_base[1] == hlf && ev_size[1] == hlf, "R5 full event", ev_base[1], hlf);
        chk(ev_cyc[1] == wr_cyc[tot-1] + 1, "R5 full timing", ev_cyc[1], wr_cyc[tot-1] + 1);
        chk(wr_addr[tot] == 0, "R5 wrap", wr_addr[tot], 0);
        chk(ev_base[2] == 0 && ev_cyc[2] == wr_cyc[tot+hlf-1] + 1, "R4 second pass", ev_base[2], 0);
        chk(busy, "R5 keeps running", int'(busy), 1);
        pulse_stop();
        chk(!busy, "R7 stop", int'(busy), 0);
      end else begin
        chk(n_wr == tot, "R6 write count", n_wr, tot);
        for (int k = 0; k < n_wr; k++)
          if (wr_addr[k] != k || wr_data[k] != vi * 4096 + k) bad++;
        chk(bad == 0, "R2 address order", bad, 0);
        bad = 0;
        for (int k = 0; k < tot; k++)
          if (ram[k] != 16'(vi * 4096 + k)) bad++;
        chk(bad == 0, "R2 memory content", bad, 0);
        chk(n_ev == 1, "R6 event count", n_ev, 1);
        chk(ev_base[0] == 0 && ev_size[0] == tot, "R6 event size", ev_size[0], tot);
        chk(ev_cyc[0] == wr_cyc[tot-1] + 1, "R6 event timing", ev_cyc[0], wr_cyc[tot-1] + 1);
        chk(!busy, "R6 idle", int'(busy), 0);
      end
    end

    // R1: refused configurations
    set_cfg(1'b1, 2, 3); pulse_start();
    chk(!busy && cfg_err, "R1 odd depth", int'(cfg_err), 1);
    set_cfg(1'b1, 2, 0); pulse_start();
    chk(!busy && cfg_err, "R1 zero depth", int'(busy), 0);
    set_cfg(1'b0, 0, 4); pulse_start();
    chk(!busy && cfg_err, "R1 zero chans", int'(busy), 0);
    set_cfg(1'b0, 17, 4); pulse_start();
    chk(!busy && cfg_err, "R1 too many chans", int'(busy), 0);
    set_cfg(1'b0, 2, 66); pulse_start();
    chk(!busy && cfg_err, "R1 depth too large", int'(busy), 0);

    // R9: results while idle
    clear_log();
    send(16'h1234); send(16'h1235); tick();
    chk(n_wr == 0 && !mem_we, "R9 idle ignore", n_wr, 0);

    // R3 / R8: stalled memory and a lost result
    set_cfg(1'b1, 2, 2); pulse_start();
    chk(!cfg_err, "R1 clear on start", int'(cfg_err), 0);
    mem_ready = 1'b0;
    send(16'hAAAA);
    chk(mem_we && mem_addr == 0 && mem_wdata == 16'hAAAA, "R3 request", int'(mem_wdata), 16'hAAAA);
    tick(); tick();
    chk(mem_we && mem_addr == 0 && mem_wdata == 16'hAAAA, "R3 hold", int'(mem_addr), 0);
    send(16'hBBBB);
    chk(ovf_err, "R8 flag", int'(ovf_err), 1);
    chk(mem_wdata == 16'hAAAA, "R8 data kept", int'(mem_wdata), 16'hAAAA);
    mem_ready = 1'b1; tick();
    chk(!mem_we, "R3 grant", int'(mem_we), 0);
    send(16'hCCCC);
    chk(mem_we && mem_addr == 1 && mem_wdata == 16'hCCCC, "R8 next address", int'(mem_addr), 1);
    tick(); tick();
    chk(ovf_err, "R8 sticky", int'(ovf_err), 1);
    pulse_stop();
    set_cfg(1'b1, 2, 4); pulse_start();
    chk(!ovf_err, "R8 clear on start", int'(ovf_err), 0);

    // R7: stop mid buffer, then restart at base
    send(1); send(2); send(3);
    clear_log();
    smp_valid = 1'b1; smp_data = 16'h00FF; stop = 1'b1; tick();
    stop = 1'b0; smp_valid = 1'b0;
    chk(!busy && !mem_we, "R7 stop", int'(busy), 0);
    repeat (3) tick();
    chk(n_ev == 0, "R7 no event", n_ev, 0);
    pulse_start();
    send(16'h0777);
    chk(mem_we && mem_addr == 0, "R7 restart at base", int'(mem_addr), 0);
    pulse_stop();

    summary();
    $finish;
  end

endmodule